// File: doc/BRIEF.md
# Dual-Core Coherence Directory with Shared L2 Arbitration

This block keeps the private L1 data caches of two cores coherent under a four-state protocol (Modified, Exclusive, Shared, Invalid). For each core it holds a mirror of that core's L1 data tags, organised as a set-associative store. Every coherence request a core sends is looked up in both mirrors in one cycle. Because the lookup reads only the mirrors, neither core is stalled to answer it. A probe goes out only when the mirror of the other core shows the line present. Lines held by the other core are moved directly between the caches, so memory is not involved. The same request path also owns the single shared L2 port. When both cores want it, a round-robin choice decides.

A core presents a request (read, read-for-ownership, writeback or evict) with a line address. Once the request is accepted, the unit returns the state and way that the requester's L1 must install. It also reports any probe to the other core and flags a cache-to-cache transfer. A request that needs the L2 port is accepted only in a cycle where the L2 side is ready.

Top module: `scu_dual`

## Requirements
- R1: After reset every mirror entry is Invalid, no request is accepted without a valid, and rsp_valid, probe_valid, xfer and l2_valid are all 0.
- R2: A read (op 0) that no mirror holds is granted Exclusive (state code 2) and raises l2_valid with l2_write 0 at l2_addr; no probe is sent.
- R3: A read that finds the line Exclusive or Shared (code 1) in the other core grants Shared, downgrades the other copy to Shared with a probe whose probe_inval is 0, sets xfer, and uses no L2 access.
- R4: A read that finds the line Modified (code 3) in the other core grants Modified to the requester, invalidates the other copy (probe_inval 1), sets xfer, and uses no L2 access.
- R5: A read-for-ownership (op 1) always grants Modified. If the other core holds the line, its copy is invalidated; xfer is set only when the requester did not already hold the line. An L2 read is issued only when neither core holds the line.
- R6: probe_valid is raised only when the other core's mirror holds the line, and probe_core always names the core that did not make the request.
- R7: A writeback (op 2) issues an L2 write and clears the requester's entry. An evict (op 3) clears the entry with no L2 access. A later read then sees the line as absent from that core.
- R8: When both cores request in one cycle, the core that was accepted most recently loses. Core 0 wins the first tie after reset, and at most one request is accepted per cycle.
- R9: A request that needs the L2 port is not accepted while l2_ready is 0. It is accepted in the first cycle where l2_ready is 1.
- R10: A fill into a set uses the lowest-numbered Invalid way. If the set is full, it uses the way named by that set's round-robin pointer (0 after reset), which then advances by one. rsp_way reports the way used, or the way hit for a line the requester already holds.
- R11: rsp_valid, rsp_core, rsp_state, rsp_way, probe_valid, probe_core, probe_inval and xfer are registered. They describe the request accepted at the previous clock edge and are valid for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 2 | Request valid, bit c for core c |
| req_op | input | 4 | Opcode, bits [2c+1:2c] for core c (0 read, 1 read-for-ownership, 2 writeback, 3 evict) |
| req_addr | input | 2*ADDR_W | Line address, slice c for core c; low bits are the set index |
| req_ready | output | 2 | Request accepted this cycle, one-hot or zero |
| l2_valid | output | 1 | Selected request needs the L2 port |
| l2_write | output | 1 | L2 access is a writeback |
| l2_addr | output | ADDR_W | L2 line address |
| l2_ready | input | 1 | L2 port can take the access this cycle |
| rsp_valid | output | 1 | Response valid |
| rsp_core | output | 1 | Core the response belongs to |
| rsp_state | output | 2 | Granted state (0 I, 1 S, 2 E, 3 M) |
| rsp_way | output | $clog2(WAYS) | Way the line occupies in the requester's L1 |
| probe_valid | output | 1 | Probe sent to the other core |
| probe_core | output | 1 | Core receiving the probe |
| probe_inval | output | 1 | 1 invalidate, 0 downgrade to Shared |
| xfer | output | 1 | Line is supplied cache-to-cache by the probed core |

## Verification
Acceptance and the L2 handshake are combinational in the cycle of the request. The bench therefore checks req_ready, l2_valid, l2_write and l2_addr shortly after it drives the inputs, before the clock edge. Every response and probe output appears one edge later. It is sampled at the following falling edge, and the request is dropped at that same moment. In a stall, the bench checks first that no grant is given while l2_ready is low, then that no response appears after that edge, and only then raises l2_ready. An arithmetic model of both mirrors and their set pointers in the bench supplies the expected state, way, probe and transfer values for directed sequences, a swept pseudo-random stream and a series of tie rounds.

// File: rtl/scu_pkg.sv
package scu_pkg;
    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } mesi_e;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_RFO   = 2'd1,
        OP_WB    = 2'd2,
        OP_EVICT = 2'd3
    } op_e;

    typedef struct packed {
        mesi_e grant;
        logic  need_l2;
        logic  l2_wr;
        logic  probe;
        logic  inval;
        logic  xfer;
    } decision_t;

    function automatic logic holds(mesi_e s);
        return s != ST_I;
    endfunction
endpackage

// File: rtl/scu_rr_arb.sv
module scu_rr_arb (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] req,
    input  logic       adv,
    output logic [1:0] gnt,
    output logic       sel
);
    logic last_q;

    always_comb begin
        if (req == 2'b11) gnt = last_q ? 2'b01 : 2'b10;
        else              gnt = req;
        sel = gnt[1];
    end

    always_ff @(posedge clk) begin
        if (rst)      last_q <= 1'b1;
        else if (adv) last_q <= sel;
    end
endmodule

// File: rtl/scu_dup_tags.sv
module scu_dup_tags
    import scu_pkg::*;
#(
    parameter int SETS  = 4,
    parameter int WAYS  = 4,
    parameter int TAG_W = 6,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             hit,
    output logic [WAY_W-1:0] hit_way,
    output mesi_e            hit_state,
    output logic [WAY_W-1:0] fill_way,
    input  logic             wr_en,
    input  logic [WAY_W-1:0] wr_way,
    input  mesi_e            wr_state,
    input  logic             fill_adv
);
    mesi_e            st_q  [SETS][WAYS];
    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    logic [WAY_W-1:0] ptr_q [SETS];
    logic             free_found;

    always_comb begin
        hit        = 1'b0;
        hit_way    = '0;
        hit_state  = ST_I;
        free_found = 1'b0;
        fill_way   = ptr_q[lk_idx];
        for (int w = 0; w < WAYS; w++) begin
            if (!hit && holds(st_q[lk_idx][w]) && tag_q[lk_idx][w] == lk_tag) begin
                hit       = 1'b1;
                hit_way   = WAY_W'(w);
                hit_state = st_q[lk_idx][w];
            end
            if (!free_found && !holds(st_q[lk_idx][w])) begin
                free_found = 1'b1;
                fill_way   = WAY_W'(w);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                ptr_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) begin
                    st_q[s][w]  <= ST_I;
                    tag_q[s][w] <= '0;
                end
            end
        end else begin
            if (wr_en) begin
                st_q[lk_idx][wr_way]  <= wr_state;
                tag_q[lk_idx][wr_way] <= lk_tag;
            end
            if (fill_adv && !free_found)
                ptr_q[lk_idx] <= ptr_q[lk_idx] + 1'b1;
        end
    end
endmodule

// File: rtl/scu_dual.sv
module scu_dual
    import scu_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int SETS   = 4,
    parameter int WAYS   = 4,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS),
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          req_valid,
    input  logic [3:0]          req_op,
    input  logic [2*ADDR_W-1:0] req_addr,
    output logic [1:0]          req_ready,
    output logic                l2_valid,
    output logic                l2_write,
    output logic [ADDR_W-1:0]   l2_addr,
    input  logic                l2_ready,
    output logic                rsp_valid,
    output logic                rsp_core,
    output logic [1:0]          rsp_state,
    output logic [WAY_W-1:0]    rsp_way,
    output logic                probe_valid,
    output logic                probe_core,
    output logic                probe_inval,
    output logic                xfer
);
    logic [1:0]        gnt;
    logic              sel, oth, accept, any_req;
    op_e               op;
    logic [ADDR_W-1:0] addr;
    decision_t         dec;

    logic              hit      [2];
    logic [WAY_W-1:0]  hit_way  [2];
    mesi_e             hit_st   [2];
    logic [WAY_W-1:0]  fill_way [2];
    logic              wr_en    [2];
    logic [WAY_W-1:0]  wr_way   [2];
    mesi_e             wr_st    [2];
    logic              fill_adv [2];
    logic [WAY_W-1:0]  own_way;

    assign any_req = |req_valid;
    assign oth     = ~sel;
    assign op      = op_e'(req_op[2*sel +: 2]);
    assign addr    = req_addr[ADDR_W*sel +: ADDR_W];

    scu_rr_arb u_arb (
        .clk (clk),
        .rst (rst),
        .req (req_valid),
        .adv (accept),
        .gnt (gnt),
        .sel (sel)
    );

    for (genvar c = 0; c < 2; c++) begin : g_core
        scu_dup_tags #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
            .clk       (clk),
            .rst       (rst),
            .lk_idx    (addr[IDX_W-1:0]),
            .lk_tag    (addr[ADDR_W-1:IDX_W]),
            .hit       (hit[c]),
            .hit_way   (hit_way[c]),
            .hit_state (hit_st[c]),
            .fill_way  (fill_way[c]),
            .wr_en     (wr_en[c]),
            .wr_way    (wr_way[c]),
            .wr_state  (wr_st[c]),
            .fill_adv  (fill_adv[c])
        );
    end

    // Coherence decision for the selected request
    always_comb begin
        dec       = '0;
        dec.grant = ST_I;
        unique case (op)
            OP_READ: begin
                if (hit[sel]) begin
                    dec.grant = hit_st[sel];
                end else if (hit[oth]) begin
                    dec.probe = 1'b1;
                    dec.xfer  = 1'b1;
                    dec.inval = (hit_st[oth] == ST_M);
                    dec.grant = (hit_st[oth] == ST_M) ? ST_M : ST_S;
                end else begin
                    dec.grant   = ST_E;
                    dec.need_l2 = 1'b1;
                end
            end
            OP_RFO: begin
                dec.grant   = ST_M;
                dec.probe   = hit[oth];
                dec.inval   = hit[oth];
                dec.xfer    = hit[oth] && !hit[sel];
                dec.need_l2 = !hit[oth] && !hit[sel];
            end
            OP_WB: begin
                dec.need_l2 = 1'b1;
                dec.l2_wr   = 1'b1;
            end
            default: ;
        endcase
    end

    assign accept    = any_req && !rst && (!dec.need_l2 || l2_ready);
    assign req_ready = accept ? gnt : 2'b00;
    assign l2_valid  = any_req && !rst && dec.need_l2;
    assign l2_write  = dec.l2_wr;
    assign l2_addr   = addr;
    assign own_way   = hit[sel] ? hit_way[sel] : fill_way[sel];

    // Mirror updates: requester installs or clears, other core follows the probe
    always_comb begin
        for (int c = 0; c < 2; c++) begin
            if (c == int'(sel)) begin
                wr_en[c]    = accept && (hit[c] || holds(dec.grant));
                wr_way[c]   = own_way;
                wr_st[c]    = dec.grant;
                fill_adv[c] = accept && !hit[c] && holds(dec.grant);
            end else begin
                wr_en[c]    = accept && dec.probe;
                wr_way[c]   = hit_way[c];
                wr_st[c]    = dec.inval ? ST_I : ST_S;
                fill_adv[c] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid   <= 1'b0;
            rsp_core    <= 1'b0;
            rsp_state   <= 2'd0;
            rsp_way     <= '0;
            probe_valid <= 1'b0;
            probe_core  <= 1'b0;
            probe_inval <= 1'b0;
            xfer        <= 1'b0;
        end else begin
            rsp_valid   <= accept;
            rsp_core    <= sel;
            rsp_state   <= dec.grant;
            rsp_way     <= own_way;
            probe_valid <= accept && dec.probe;
            probe_core  <= oth;
            probe_inval <= dec.inval;
            xfer        <= accept && dec.xfer;
        end
    end
endmodule

// File: rtl/scu_dual_chk.sv
module scu_dual_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] req_valid,
    input logic [1:0] req_ready,
    input logic [1:0] gnt,
    input logic       l2_valid,
    input logic       l2_ready,
    input logic       rsp_valid,
    input logic       rsp_core,
    input logic [1:0] rsp_state,
    input logic       probe_valid,
    input logic       probe_core,
    input logic       probe_inval,
    input logic       xfer
);
    a_r9_l2_stall: assert property (@(posedge clk) disable iff (rst)
        (l2_valid && !l2_ready) |-> (req_ready == 2'b00));

    a_r8_single_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(req_ready));

    a_r8_tie_turns: assert property (@(posedge clk) disable iff (rst)
        (req_valid == 2'b11 && $past(req_ready) == 2'b01) |-> (gnt == 2'b10));

    a_r11_resp_next: assert property (@(posedge clk) disable iff (rst)
        (req_ready != 2'b00) |=> rsp_valid);

    a_r6_probe_other: assert property (@(posedge clk) disable iff (rst)
        probe_valid |-> (rsp_valid && probe_core != rsp_core));

    a_r4_mod_alone: assert property (@(posedge clk) disable iff (rst)
        (probe_valid && rsp_state == 2'd3) |-> probe_inval);

    a_r3_shared_keeps: assert property (@(posedge clk) disable iff (rst)
        (probe_valid && rsp_state == 2'd1) |-> !probe_inval);

    a_r5_xfer_probed: assert property (@(posedge clk) disable iff (rst)
        xfer |-> probe_valid);
endmodule

bind scu_dual scu_dual_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .gnt         (gnt),
    .l2_valid    (l2_valid),
    .l2_ready    (l2_ready),
    .rsp_valid   (rsp_valid),
    .rsp_core    (rsp_core),
    .rsp_state   (rsp_state),
    .probe_valid (probe_valid),
    .probe_core  (probe_core),
    .probe_inval (probe_inval),
    .xfer        (xfer)
);

// File: tb/scu_dual_test.sv
module scu_dual_test;
    localparam int AW = 8;
    localparam int NS = 4;
    localparam int NW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    req_valid = '0;
    logic [3:0]    req_op = '0;
    logic [2*AW-1:0] req_addr = '0;
    logic [1:0]    req_ready;
    logic          l2_valid, l2_write;
    logic [AW-1:0] l2_addr;
    logic          l2_ready = 1'b1;
    logic          rsp_valid, rsp_core;
    logic [1:0]    rsp_state, rsp_way;
    logic          probe_valid, probe_core, probe_inval, xfer;

    scu_dual #(.ADDR_W(AW), .SETS(NS), .WAYS(NW)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_ready(req_ready), .l2_valid(l2_valid),
        .l2_write(l2_write), .l2_addr(l2_addr), .l2_ready(l2_ready),
        .rsp_valid(rsp_valid), .rsp_core(rsp_core), .rsp_state(rsp_state),
        .rsp_way(rsp_way), .probe_valid(probe_valid), .probe_core(probe_core),
        .probe_inval(probe_inval), .xfer(xfer)
    );

    always #4 clk = ~clk;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    // bench model: state 0 I, 1 S, 2 E, 3 M
    int mst [2][NS][NW];
    int mtg [2][NS][NW];
    int mptr [2][NS];
    int lastc = 1;

    int e_st, e_way, e_pr, e_inv, e_xf, e_l2, e_l2w;

    task automatic chk(input string rq, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic int find(input int c, input int s, input int t);
        for (int w = 0; w < NW; w++)
            if (mst[c][s][w] != 0 && mtg[c][s][w] == t) return w;
        return -1;
    endfunction

    function automatic int free_way(input int c, input int s);
        for (int w = 0; w < NW; w++)
            if (mst[c][s][w] == 0) return w;
        return -1;
    endfunction

    task automatic model_eval(input int c, input int opc, input int a);
        int s, t, o, ow, hw;
        s = a % NS; t = a / NS; o = 1 - c;
        ow = find(c, s, t); hw = find(o, s, t);
        e_pr = 0; e_inv = 0; e_xf = 0; e_l2 = 0; e_l2w = 0; e_st = 0;
        if (opc == 0) begin
            if (ow >= 0) e_st = mst[c][s][ow];
            else if (hw >= 0) begin
                e_pr = 1; e_xf = 1;
                e_inv = (mst[o][s][hw] == 3);
                e_st = e_inv ? 3 : 1;
            end else begin e_st = 2; e_l2 = 1; end
        end else if (opc == 1) begin
            e_st = 3;
            e_pr = (hw >= 0); e_inv = e_pr;
            e_xf = (hw >= 0) && (ow < 0);
            e_l2 = (hw < 0) && (ow < 0);
        end else if (opc == 2) begin
            e_l2 = 1; e_l2w = 1;
        end
        if (ow >= 0) e_way = ow;
        else if (free_way(c, s) >= 0) e_way = free_way(c, s);
        else e_way = mptr[c][s];
    endtask

    task automatic model_apply(input int c, input int opc, input int a);
        int s, t, o, ow, hw;
        s = a % NS; t = a / NS; o = 1 - c;
        ow = find(c, s, t); hw = find(o, s, t);
        model_eval(c, opc, a);
        if (e_pr != 0) mst[o][s][hw] = e_inv ? 0 : 1;
        if (ow < 0 && e_st != 0 && free_way(c, s) < 0)
            mptr[c][s] = (mptr[c][s] + 1) % NW;
        if (ow >= 0 || e_st != 0) begin
            mst[c][s][e_way] = e_st;
            mtg[c][s][e_way] = t;
        end
        lastc = c;
    endtask

    task automatic drive(input int c, input int opc, input int a);
        req_valid[c] = 1'b1;
        req_op[2*c +: 2] = 2'(opc);
        req_addr[AW*c +: AW] = AW'(a);
    endtask

    task automatic issue(input int c, input int opc, input int a, input bit rdy);
        model_eval(c, opc, a);
        @(negedge clk);
        drive(c, opc, a);
        l2_ready = rdy;
        #1;
        chk(opc == 2 ? "R7 l2_valid" : "R2 l2_valid", int'(l2_valid), e_l2);
        if (e_l2 != 0) begin
            chk("R7 l2_write", int'(l2_write), e_l2w);
            chk("R2 l2_addr", int'(l2_addr), a);
        end
        if (e_l2 != 0 && !rdy) begin
            chk("R9 stalled grant", int'(req_ready), 0);
            @(negedge clk);
            chk("R9 no response while stalled", int'(rsp_valid), 0);
            l2_ready = 1'b1;
            #1;
        end
        chk("R8 grant", int'(req_ready), 1 << c);
        @(negedge clk);
        req_valid = '0;
        chk("R11 rsp_valid", int'(rsp_valid), 1);
        chk("R11 rsp_core", int'(rsp_core), c);
        chk(opc == 1 ? "R5 state" : "R3 state", int'(rsp_state), e_st);
        chk(e_inv != 0 && opc == 0 ? "R4 probe" : "R6 probe", int'(probe_valid), e_pr);
        if (e_pr != 0) begin
            chk("R6 probe_core", int'(probe_core), 1 - c);
            chk("R4 probe_inval", int'(probe_inval), e_inv);
        end
        chk("R5 xfer", int'(xfer), e_xf);
        if (e_st != 0) chk("R10 rsp_way", int'(rsp_way), e_way);
        model_apply(c, opc, a);
    endtask

    task automatic tie(input int op0, input int a0, input int op1, input int a1);
        int w, l, wop, wa, lop, la;
        w = (lastc == 0) ? 1 : 0; l = 1 - w;
        wop = w == 0 ? op0 : op1; wa = w == 0 ? a0 : a1;
        lop = w == 0 ? op1 : op0; la = w == 0 ? a1 : a0;
        @(negedge clk);
        l2_ready = 1'b1;
        drive(0, op0, a0);
        drive(1, op1, a1);
        model_eval(w, wop, wa);
        #1;
        chk("R8 tie winner", int'(req_ready), 1 << w);
        @(negedge clk);
        chk("R8 tie rsp_core", int'(rsp_core), w);
        chk("R8 tie state", int'(rsp_state), e_st);
        model_apply(w, wop, wa);
        req_valid[w] = 1'b0;
        model_eval(l, lop, la);
        #1;
        chk("R8 loser served next", int'(req_ready), 1 << l);
        @(negedge clk);
        req_valid = '0;
        chk("R8 loser rsp_core", int'(rsp_core), l);
        chk("R8 loser state", int'(rsp_state), e_st);
        model_apply(l, lop, la);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        int lf;
        for (int c = 0; c < 2; c++)
            for (int s = 0; s < NS; s++) begin
                mptr[c][s] = 0;
                for (int w = 0; w < NW; w++) begin mst[c][s][w] = 0; mtg[c][s][w] = 0; end
            end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 req_ready", int'(req_ready), 0);
        chk("R1 l2_valid", int'(l2_valid), 0);
        @(negedge clk);
        chk("R1 rsp_valid", int'(rsp_valid), 0);
        chk("R1 probe_valid", int'(probe_valid), 0);
        chk("R1 xfer", int'(xfer), 0);

        // directed walk through each set
        for (int s = 0; s < NS; s++) begin
            int a;
            a = (5 << 2) | s;
            issue(0, 0, a, 1);   // R2: exclusive fill
            issue(1, 0, a, 1);   // R3: shared copy
            issue(1, 1, a, 0);   // R5: upgrade, stall ignored (no L2)
            issue(0, 0, a, 1);   // R4: dirty migrate
            issue(0, 2, a, 0);   // R7 writeback with R9 stall
            issue(1, 0, a, 1);   // R7: line gone, exclusive again
            issue(1, 3, a, 1);   // R7 evict
            issue(0, 1, a, 0);   // R5 fresh ownership, R9 stall
        end

        // R10: fill one set past capacity
        for (int t = 0; t < 7; t++) issue(1, 0, (t << 2) | 2, 1);

        // swept pseudo-random stream over a small address space
        lf = 32'h1ACE;
        for (int i = 0; i < 400; i++) begin
            lf = (lf >> 1) ^ ((lf & 1) != 0 ? 32'hB400 : 0);
            issue(lf & 1, (lf >> 1) & 3, (((lf >> 3) % 6) << 2) | ((lf >> 7) & 1), ((lf >> 9) & 1) != 0);
        end

        // R8: repeated ties
        for (int i = 0; i < 6; i++) tie(i % 4, (i << 2) | 3, (i + 1) % 4, ((i + 2) << 2) | 3);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule